// File: doc/BRIEF.md
# CPU Clock Source and Low-Power Mode Sequencer

This block chooses where the CPU clock of a small microcontroller comes from and how far it is divided. There are two sources: an external crystal input and an on-chip oscillator. The block also decides which of the two oscillators runs. Software drives it through single-cycle write strobes:

- a two-bit source field, which carries the external divide ratio as well;
- a separate on-chip ratio;
- a stop bit for each oscillator;
- an enable bit for the oscillation-stop detector.

Two more strobes enter the low-power modes: a WAIT strobe, which gates the CPU clock, and a STOP strobe, which halts both oscillators. An interrupt request brings the block back from either mode.

All control is plain single-cycle strobes and level flags. There is no streaming interface, so no valid/ready handshake applies. Register updates take effect on the clock edge that samples the strobe. The outputs are decoded from the registered state, so they are visible one edge after the strobe.

Six running states exist:

| Code | Source | Oscillators running | Stop detector |
|------|--------|---------------------|---------------|
| 0 | external | external only | off |
| 1 | external | both | off |
| 2 | on-chip | both | off |
| 3 | on-chip | on-chip only | off |
| 4 | external | both | armed |
| 5 | on-chip | both | armed |

The mode code is RUN 0, WAIT 1, STOP 2 and WAKE 3. The exported state code is `{mode, running_state}`.

When several strobes arrive in one cycle, the order of precedence is: STOP, then WAIT, then the source write, then the external-stop write, then the on-chip-stop write, then the detector write.

Top module: `cmc_top`

## Requirements
- R1: After reset the block is in RUN mode, in running state 2 (on-chip source), with `div_sel` = 2'b10 (/8). Both oscillator enables and `cpu_clk_en` are 1, and `det_arm` is 0.
- R2: On an external-source state, writing the source field with 00, 01 or 11 sets `div_sel` to 01 (/2), 10 (/8) or 00 (/1) respectively. The `div_sel` codes are 00=/1, 01=/2, 10=/8 and 11=/128.
- R3: Writing the source field with 10 from state 1 or 4 moves to state 2 or 5 respectively, and forces `div_sel` to 10 whatever `rc_ratio` holds. The same write made while the on-chip source is already selected copies `rc_ratio` into `div_sel`.
- R4: A write of 00, 01 or 11 from state 2 or 5 is held while `xt_stable` is 0. It completes on the first edge where `xt_stable` is 1, going to state 1 or 4 with the divider of the held field. `cpu_clk_en` stays 1 for the whole wait.
- R5: In state 2, writing the external-stop bit as 1 goes to state 3 with `xt_en` = 0, and writing it as 0 returns to state 2. In state 1, writing the on-chip-stop bit as 1 goes to state 0 with `rc_en` = 0, and writing it as 0 returns to state 1.
- R6: A write that would stop the oscillator currently in use is ignored, and so is a source write towards an oscillator that is stopped. The state and the enables stay unchanged.
- R7: Writing the detector bit as 1 moves state 1 to 4, and moves state 2 to 5 (the latter only while `xt_stable` is 1). While in state 4 or 5 `det_arm` is 1. Writing the bit as 0 returns to the unprimed state. Source writes inside the primed pair use the same field encoding.
- R8: A WAIT strobe in RUN sets the mode to WAIT and drops `cpu_clk_en`, leaving the oscillator enables as they were. An interrupt returns to RUN in the same running state.
- R9: A STOP strobe drops both oscillator enables and `cpu_clk_en`. An interrupt then enters WAKE, which restores the enables of the saved state. `cpu_clk_en` returns only once the stable flag of the selected source is 1, with the state and divider from before the STOP.
- R10: Source, stop-bit and detector writes made outside RUN mode leave the running state and the divider unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | block clock |
| rst_n | input | 1 | active-low asynchronous reset |
| src_wr | input | 1 | source field write strobe |
| src_fld | input | 2 | source field value (10 = on-chip, others external with ratio) |
| rc_ratio | input | 2 | on-chip divide ratio, coded as `div_sel` |
| xstop_wr | input | 1 | external-oscillator stop bit write strobe |
| xstop_val | input | 1 | value written to the external stop bit |
| rcstop_wr | input | 1 | on-chip oscillator stop bit write strobe |
| rcstop_val | input | 1 | value written to the on-chip stop bit |
| det_wr | input | 1 | stop-detector enable write strobe |
| det_val | input | 1 | value written to the detector enable |
| wait_req | input | 1 | WAIT instruction strobe |
| stop_req | input | 1 | STOP instruction strobe |
| wake_irq | input | 1 | interrupt wake request |
| xt_stable | input | 1 | external oscillation is stable |
| rc_stable | input | 1 | on-chip oscillation is stable |
| xt_en | output | 1 | external oscillator enable |
| rc_en | output | 1 | on-chip oscillator enable |
| div_sel | output | 2 | CPU clock divider select |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| det_arm | output | 1 | oscillation-stop detector armed |
| state_code | output | 5 | {mode, running state} |

## Verification
The assertions guard these properties on every cycle:

- a pending switch to the external clock never completes while the external flag is low;
- every entry into an on-chip state lands on /8;
- the oscillator feeding the CPU is never disabled while running;
- STOP disables both oscillators;
- WAKE holds until its source is stable;
- the running state is frozen outside RUN.

Only the directed scenarios show the actual field-to-divider encodings, the ignored writes in the single-oscillator states, the primed-pair round trip and the restoration of the divider after a STOP.

// File: rtl/cmc_pkg.sv
package cmc_pkg;

  typedef enum logic [2:0] {
    RS_XT_SOLO = 3'd0,
    RS_XT      = 3'd1,
    RS_RC      = 3'd2,
    RS_RC_SOLO = 3'd3,
    RS_XT_DET  = 3'd4,
    RS_RC_DET  = 3'd5
  } run_st_e;

  typedef enum logic [1:0] {
    PM_RUN  = 2'd0,
    PM_WAIT = 2'd1,
    PM_STOP = 2'd2,
    PM_WAKE = 2'd3
  } pmode_e;

  localparam int DIV_W = 2;
  localparam logic [DIV_W-1:0] DIV_1   = 2'b00;
  localparam logic [DIV_W-1:0] DIV_2   = 2'b01;
  localparam logic [DIV_W-1:0] DIV_8   = 2'b10;
  localparam logic [DIV_W-1:0] DIV_128 = 2'b11;
  localparam logic [1:0]       FLD_RC  = 2'b10;

  function automatic logic on_rc(run_st_e s);
    return (s == RS_RC) || (s == RS_RC_SOLO) || (s == RS_RC_DET);
  endfunction

  function automatic logic [DIV_W-1:0] ext_div(logic [1:0] f);
    case (f)
      2'b00:   return DIV_2;
      2'b01:   return DIV_8;
      default: return DIV_1;
    endcase
  endfunction

endpackage

// File: rtl/cmc_src_sel.sv
module cmc_src_sel
  import cmc_pkg::*;
#(
  parameter logic [DIV_W-1:0] RST_DIV = DIV_8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             src_wr,
  input  logic [1:0]       src_fld,
  input  logic [DIV_W-1:0] rc_ratio,
  input  logic             xstop_wr,
  input  logic             xstop_val,
  input  logic             rcstop_wr,
  input  logic             rcstop_val,
  input  logic             det_wr,
  input  logic             det_val,
  input  logic             xt_stable,
  output run_st_e          run_st,
  output logic [DIV_W-1:0] div_sel
);

  run_st_e          st_q, st_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic             pend_q, pend_d;
  logic [1:0]       pfld_q, pfld_d;

  always_comb begin
    st_d   = st_q;
    div_d  = div_q;
    pend_d = pend_q;
    pfld_d = pfld_q;
    if (!run_en) begin
      pend_d = 1'b0;
    end else begin
      if (src_wr) begin
        if (src_fld == FLD_RC) begin
          pend_d = 1'b0;
          case (st_q)
            RS_XT:     begin st_d = RS_RC;     div_d = DIV_8; end
            RS_XT_DET: begin st_d = RS_RC_DET; div_d = DIV_8; end
            RS_RC, RS_RC_SOLO, RS_RC_DET: div_d = rc_ratio;
            default: ;
          endcase
        end else begin
          case (st_q)
            RS_XT, RS_XT_SOLO, RS_XT_DET: div_d = ext_div(src_fld);
            RS_RC, RS_RC_DET: begin pend_d = 1'b1; pfld_d = src_fld; end
            default: ;
          endcase
        end
      end else if (xstop_wr) begin
        if (st_q == RS_RC && xstop_val) begin
          st_d   = RS_RC_SOLO;
          pend_d = 1'b0;
        end else if (st_q == RS_RC_SOLO && !xstop_val) begin
          st_d = RS_RC;
        end
      end else if (rcstop_wr) begin
        if (st_q == RS_XT && rcstop_val)           st_d = RS_XT_SOLO;
        else if (st_q == RS_XT_SOLO && !rcstop_val) st_d = RS_XT;
      end else if (det_wr) begin
        case (st_q)
          RS_XT:     if (det_val) st_d = RS_XT_DET;
          RS_RC:     if (det_val && xt_stable) st_d = RS_RC_DET;
          RS_XT_DET: if (!det_val) st_d = RS_XT;
          RS_RC_DET: if (!det_val) st_d = RS_RC;
          default: ;
        endcase
      end
      // a held switch to the external clock lands on the first stable edge
      if (pend_d && xt_stable) begin
        st_d   = (st_d == RS_RC_DET) ? RS_XT_DET : RS_XT;
        div_d  = ext_div(pfld_d);
        pend_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RS_RC;
      div_q  <= RST_DIV;
      pend_q <= 1'b0;
      pfld_q <= 2'b00;
    end else begin
      st_q   <= st_d;
      div_q  <= div_d;
      pend_q <= pend_d;
      pfld_q <= pfld_d;
    end
  end

  assign run_st  = st_q;
  assign div_sel = div_q;

  p_hold_unstable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (on_rc(st_q) && !xt_stable) |=> on_rc(st_q));

  p_to_rc_div8_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!on_rc(st_q) && src_wr && run_en) |=> (on_rc(st_q) -> (div_q == DIV_8)));

endmodule

// File: rtl/cmc_pwr_seq.sv
module cmc_pwr_seq
  import cmc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   wait_req,
  input  logic   stop_req,
  input  logic   wake_irq,
  input  logic   src_stable,
  output pmode_e mode
);

  pmode_e m_q, m_d;

  always_comb begin
    m_d = m_q;
    case (m_q)
      PM_RUN: begin
        if (stop_req)      m_d = PM_STOP;
        else if (wait_req) m_d = PM_WAIT;
      end
      PM_WAIT: if (wake_irq)   m_d = PM_RUN;
      PM_STOP: if (wake_irq)   m_d = PM_WAKE;
      PM_WAKE: if (src_stable) m_d = PM_RUN;
      default: m_d = PM_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_q <= PM_RUN;
    else        m_q <= m_d;
  end

  assign mode = m_q;

  p_wake_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (m_q == PM_WAKE && !src_stable) |=> (m_q == PM_WAKE));

  p_wait_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (m_q == PM_WAIT && !wake_irq) |=> (m_q == PM_WAIT));

endmodule

// File: rtl/cmc_osc_out.sv
module cmc_osc_out
  import cmc_pkg::*;
(
  input  run_st_e run_st,
  input  pmode_e  mode,
  output logic    xt_en,
  output logic    rc_en,
  output logic    cpu_clk_en,
  output logic    det_arm
);

  logic halted;

  always_comb begin
    halted     = (mode == PM_STOP);
    xt_en      = !halted && (run_st != RS_RC_SOLO);
    rc_en      = !halted && (run_st != RS_XT_SOLO);
    cpu_clk_en = (mode == PM_RUN);
    det_arm    = !halted && ((run_st == RS_XT_DET) || (run_st == RS_RC_DET));
  end

endmodule

// File: rtl/cmc_top.sv
module cmc_top
  import cmc_pkg::*;
#(
  parameter logic [1:0] RST_DIV = 2'b10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       src_wr,
  input  logic [1:0] src_fld,
  input  logic [1:0] rc_ratio,
  input  logic       xstop_wr,
  input  logic       xstop_val,
  input  logic       rcstop_wr,
  input  logic       rcstop_val,
  input  logic       det_wr,
  input  logic       det_val,
  input  logic       wait_req,
  input  logic       stop_req,
  input  logic       wake_irq,
  input  logic       xt_stable,
  input  logic       rc_stable,
  output logic       xt_en,
  output logic       rc_en,
  output logic [1:0] div_sel,
  output logic       cpu_clk_en,
  output logic       det_arm,
  output logic [4:0] state_code
);

  run_st_e run_st;
  pmode_e  mode;
  logic    run_en;
  logic    src_stable;

  assign run_en     = (mode == PM_RUN) && !wait_req && !stop_req;
  assign src_stable = on_rc(run_st) ? rc_stable : xt_stable;

  cmc_src_sel #(.RST_DIV(RST_DIV)) u_src (
    .clk(clk), .rst_n(rst_n), .run_en(run_en),
    .src_wr(src_wr), .src_fld(src_fld), .rc_ratio(rc_ratio),
    .xstop_wr(xstop_wr), .xstop_val(xstop_val),
    .rcstop_wr(rcstop_wr), .rcstop_val(rcstop_val),
    .det_wr(det_wr), .det_val(det_val), .xt_stable(xt_stable),
    .run_st(run_st), .div_sel(div_sel)
  );

  cmc_pwr_seq u_pwr (
    .clk(clk), .rst_n(rst_n), .wait_req(wait_req), .stop_req(stop_req),
    .wake_irq(wake_irq), .src_stable(src_stable), .mode(mode)
  );

  cmc_osc_out u_out (
    .run_st(run_st), .mode(mode), .xt_en(xt_en), .rc_en(rc_en),
    .cpu_clk_en(cpu_clk_en), .det_arm(det_arm)
  );

  assign state_code = {mode, run_st};

  p_src_osc_on_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PM_RUN) |-> (on_rc(run_st) ? rc_en : xt_en));

  p_stop_halts_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PM_STOP) |-> (!xt_en && !rc_en && !cpu_clk_en));

  p_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != PM_RUN) |=> ($stable(run_st) && $stable(div_sel)));

endmodule

// File: tb/cmc_top_bench.sv
`timescale 1ns/1ps
module cmc_top_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic src_wr = 0, xstop_wr = 0, xstop_val = 0, rcstop_wr = 0, rcstop_val = 0;
  logic det_wr = 0, det_val = 0, wait_req = 0, stop_req = 0, wake_irq = 0;
  logic xt_stable = 0, rc_stable = 1;
  logic [1:0] src_fld = 0, rc_ratio = 0;
  logic xt_en, rc_en, cpu_clk_en, det_arm;
  logic [1:0] div_sel;
  logic [4:0] state_code;

  int n_run = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cmc_top u_cmc_top (
    .clk(clk), .rst_n(rst_n), .src_wr(src_wr), .src_fld(src_fld), .rc_ratio(rc_ratio),
    .xstop_wr(xstop_wr), .xstop_val(xstop_val), .rcstop_wr(rcstop_wr), .rcstop_val(rcstop_val),
    .det_wr(det_wr), .det_val(det_val), .wait_req(wait_req), .stop_req(stop_req),
    .wake_irq(wake_irq), .xt_stable(xt_stable), .rc_stable(rc_stable),
    .xt_en(xt_en), .rc_en(rc_en), .div_sel(div_sel), .cpu_clk_en(cpu_clk_en),
    .det_arm(det_arm), .state_code(state_code)
  );

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic wr_src(logic [1:0] f, logic [1:0] r);
    @(negedge clk); src_wr = 1; src_fld = f; rc_ratio = r;
    @(negedge clk); src_wr = 0;
  endtask
  task automatic wr_xstop(logic v);
    @(negedge clk); xstop_wr = 1; xstop_val = v;
    @(negedge clk); xstop_wr = 0;
  endtask
  task automatic wr_rcstop(logic v);
    @(negedge clk); rcstop_wr = 1; rcstop_val = v;
    @(negedge clk); rcstop_wr = 0;
  endtask
  task automatic wr_det(logic v);
    @(negedge clk); det_wr = 1; det_val = v;
    @(negedge clk); det_wr = 0;
  endtask
  task automatic pulse_wait();
    @(negedge clk); wait_req = 1; @(negedge clk); wait_req = 0;
  endtask
  task automatic pulse_stop();
    @(negedge clk); stop_req = 1; @(negedge clk); stop_req = 0;
  endtask
  task automatic pulse_wake();
    @(negedge clk); wake_irq = 1; @(negedge clk); wake_irq = 0;
  endtask

  task automatic t_reset();
    chk("R1 state", 8'(state_code), 8'd2);
    chk("R1 div", 8'(div_sel), 8'd2);
    chk("R1 xt_en", 8'(xt_en), 8'd1);
    chk("R1 rc_en", 8'(rc_en), 8'd1);
    chk("R1 clk_en", 8'(cpu_clk_en), 8'd1);
    chk("R1 det_arm", 8'(det_arm), 8'd0);
  endtask

  task automatic t_rc_ratio();
    wr_src(2'b10, 2'b11); chk("R3 ratio128", 8'(div_sel), 8'd3);
    wr_src(2'b10, 2'b00); chk("R3 ratio1", 8'(div_sel), 8'd0);
    wr_src(2'b10, 2'b10); chk("R3 ratio8", 8'(div_sel), 8'd2);
  endtask

  task automatic t_to_ext_hold();
    xt_stable = 0;
    wr_src(2'b01, 2'b00);
    for (int i = 0; i < 4; i++) begin
      chk("R4 held state", 8'(state_code), 8'd2);
      chk("R4 clk_en", 8'(cpu_clk_en), 8'd1);
      @(negedge clk);
    end
    xt_stable = 1;
    @(negedge clk);
    chk("R4 switched", 8'(state_code), 8'd1);
    chk("R4 div", 8'(div_sel), 8'd2);
    chk("R4 clk_en", 8'(cpu_clk_en), 8'd1);
  endtask

  task automatic t_ext_fields();
    wr_src(2'b00, 2'b00); chk("R2 fld00", 8'(div_sel), 8'd1);
    wr_src(2'b11, 2'b00); chk("R2 fld11", 8'(div_sel), 8'd0);
    wr_src(2'b01, 2'b00); chk("R2 fld01", 8'(div_sel), 8'd2);
    wr_src(2'b11, 2'b00);
  endtask

  task automatic t_ext_to_rc();
    wr_src(2'b10, 2'b11);
    chk("R3 to rc state", 8'(state_code), 8'd2);
    chk("R3 forced div8", 8'(div_sel), 8'd2);
  endtask

  task automatic t_stop_in_use();
    wr_rcstop(1'b1);
    chk("R6 rcstop ignored", 8'(state_code), 8'd2);
    chk("R6 rc_en kept", 8'(rc_en), 8'd1);
    wr_xstop(1'b1);
    chk("R5 rc solo", 8'(state_code), 8'd3);
    chk("R5 xt off", 8'(xt_en), 8'd0);
    wr_src(2'b00, 2'b00);
    chk("R6 ext src ignored", 8'(state_code), 8'd3);
    wr_xstop(1'b0);
    chk("R5 xt back", 8'(state_code), 8'd2);
    chk("R5 xt_en", 8'(xt_en), 8'd1);
    wr_src(2'b00, 2'b00);
    chk("R4 immediate", 8'(state_code), 8'd1);
    chk("R2 div2", 8'(div_sel), 8'd1);
    wr_rcstop(1'b1);
    chk("R5 xt solo", 8'(state_code), 8'd0);
    chk("R5 rc off", 8'(rc_en), 8'd0);
    wr_src(2'b10, 2'b00);
    chk("R6 rc src ignored", 8'(state_code), 8'd0);
    wr_xstop(1'b1);
    chk("R6 xstop ignored", 8'(state_code), 8'd0);
    chk("R6 xt_en kept", 8'(xt_en), 8'd1);
    wr_rcstop(1'b0);
    chk("R5 rc back", 8'(state_code), 8'd1);
  endtask

  task automatic t_detect();
    wr_det(1'b1);
    chk("R7 primed ext", 8'(state_code), 8'd4);
    chk("R7 det_arm", 8'(det_arm), 8'd1);
    wr_src(2'b10, 2'b00);
    chk("R7 primed rc", 8'(state_code), 8'd5);
    chk("R7 div8", 8'(div_sel), 8'd2);
    xt_stable = 0;
    wr_src(2'b11, 2'b00);
    chk("R7 held", 8'(state_code), 8'd5);
    xt_stable = 1;
    @(negedge clk);
    chk("R7 back ext", 8'(state_code), 8'd4);
    chk("R7 div1", 8'(div_sel), 8'd0);
    wr_det(1'b0);
    chk("R7 unprimed", 8'(state_code), 8'd1);
    chk("R7 det_arm off", 8'(det_arm), 8'd0);
  endtask

  task automatic t_wait();
    pulse_wait();
    chk("R8 wait code", 8'(state_code), 8'd9);
    chk("R8 clk_en", 8'(cpu_clk_en), 8'd0);
    chk("R8 xt_en", 8'(xt_en), 8'd1);
    chk("R8 rc_en", 8'(rc_en), 8'd1);
    wr_src(2'b10, 2'b00);
    chk("R10 wait write", 8'(state_code), 8'd9);
    chk("R10 div", 8'(div_sel), 8'd0);
    pulse_wake();
    chk("R8 resumed", 8'(state_code), 8'd1);
    chk("R8 clk_en", 8'(cpu_clk_en), 8'd1);
  endtask

  task automatic t_stop();
    pulse_stop();
    xt_stable = 0;
    chk("R9 stop code", 8'(state_code), 8'd17);
    chk("R9 xt_en", 8'(xt_en), 8'd0);
    chk("R9 rc_en", 8'(rc_en), 8'd0);
    chk("R9 clk_en", 8'(cpu_clk_en), 8'd0);
    wr_xstop(1'b1);
    chk("R10 stop write", 8'(state_code), 8'd17);
    pulse_wake();
    for (int i = 0; i < 3; i++) begin
      chk("R9 wake code", 8'(state_code), 8'd25);
      chk("R9 wake clk_en", 8'(cpu_clk_en), 8'd0);
      chk("R9 wake xt_en", 8'(xt_en), 8'd1);
      @(negedge clk);
    end
    xt_stable = 1;
    @(negedge clk);
    chk("R9 restored", 8'(state_code), 8'd1);
    chk("R9 div kept", 8'(div_sel), 8'd0);
    chk("R9 clk_en", 8'(cpu_clk_en), 8'd1);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000 && !done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: got %0d expected %0d", cyc, 20000);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_rc_ratio();
    t_to_ext_hold();
    t_ext_fields();
    t_ext_to_rc();
    t_stop_in_use();
    t_detect();
    t_wait();
    t_stop();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule